// File: doc/BRIEF.md
# Paged Nonvolatile Write Buffer Controller

This block stands on the host side of a byte-wide paged nonvolatile memory and runs in one synchronous clock domain. The host drives active-low chip-enable, write-enable and output-enable strobes, a 17-bit address and an 8-bit data bus, all sampled on the rising clock edge. Each completed write strobe places one byte into a one-page buffer and marks that byte valid. Bytes may arrive in any order, and a later byte overwrites an earlier one at the same position.

A new byte must arrive before the load window runs out. When no byte has been accepted for `LOAD_CYC` cycles, loading closes and a timed programming period of `PROG_CYC` cycles begins. At its end only the valid bytes are copied into the behavioural array and the mask is cleared. While loading and programming are in progress, `busy` is high and every read returns a status byte. The strobes are a memory-style bus, so there is no valid/ready handshake and no back-pressure: a strobe that arrives while programming runs is dropped. The array holds `MEM_PAGES` pages, indexed by the low page-address bits.

Top module: `pagebuf_ctrl`

## Requirements
- R1: After reset, `busy` and `err_page` are 0, `dout` is 0, and every array byte reads 0xFF.
- R2: A write strobe is active while `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is taken in the first cycle the strobe is seen active, which is the later of the two enable falls, and later address changes are ignored.
- R3: The data byte is the `din` value in the first cycle the strobe is seen inactive, which is the earlier of the two enable rises. If the strobe ends because `oe_n` went low, or if it was never active, no byte is loaded.
- R4: Address bits 16..7 select the page and bits 6..0 select the byte. Bytes load in any order, and the last byte written to a position is the one programmed.
- R5: `busy` rises in the cycle after the first accepted byte. It falls exactly `LOAD_CYC`+`PROG_CYC` cycles after the last accepted byte.
- R6: Each accepted byte restarts the load window. Programming begins once `LOAD_CYC` cycles pass with no accepted byte.
- R7: Programming writes only the valid bytes, and the other bytes of that page keep their values. The valid mask is clear when `busy` falls.
- R8: While loading, a byte whose page bits differ from those of the first byte is ignored and sets `err_page`. `err_page` stays set until reset.
- R9: A write strobe that completes during programming is ignored.
- R10: A read (`ce_n`=0, `oe_n`=0, `we_n`=1) in one cycle sets `dout` in the next. When idle, `dout` is the array byte. When busy, it is the last accepted byte with bit 7 inverted. Without a read, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address: page in 16..7, byte in 6..0 |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status byte |
| busy | output | 1 | Loading or programming in progress |
| err_page | output | 1 | Sticky off-page load flag |

## Verification
The hardest cases are at the edges of the load window. A byte must land a few cycles before the window closes, so that it restarts the window, and another must land a few cycles after it closes, so that it meets the programming period and is dropped. The bench uses short window and programming parameters. It counts the cycles its write task spends from the first enable fall to the committing edge, and places the second byte by padding idle cycles so that the commit falls just inside or just outside the window. It then times the fall of `busy` and reads both addresses back.

// File: rtl/pagebuf_pkg.sv
package pagebuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pb_state_e;
endpackage

// File: rtl/pb_strobe.sv
module pb_strobe #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req
);
  logic act, act_q;

  // strobe window: both enables low, outputs disabled
  assign act = ~ce_n & ~we_n & oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_addr <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) wr_addr <= addr;
    end
  end

  // closing edge commits only when outputs are still disabled
  assign wr_stb  = act_q & ~act & oe_n;
  assign wr_data = din;
  assign rd_req  = ~ce_n & ~oe_n & we_n;
endmodule

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import pagebuf_pkg::*;
#(
  parameter int PW       = 10,
  parameter int LOAD_CYC = 15000,
  parameter int PROG_CYC = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [PW-1:0] wr_page,
  output pb_state_e     state,
  output logic [PW-1:0] page_tag,
  output logic          ld,
  output logic          prog_done,
  output logic          err_page
);
  localparam int MAXC = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          bad;

  assign ld = wr_stb & ((state == ST_IDLE) |
                        ((state == ST_LOAD) & (wr_page == page_tag)));
  assign bad       = wr_stb & (state == ST_LOAD) & (wr_page != page_tag);
  assign prog_done = (state == ST_PROG) & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      page_tag <= '0;
      err_page <= 1'b0;
    end else begin
      if (bad) err_page <= 1'b1;
      case (state)
        ST_IDLE: if (ld) begin
          state    <= ST_LOAD;
          cnt      <= CW'(LOAD_CYC - 1);
          page_tag <= wr_page;
        end
        ST_LOAD: begin
          if (ld) cnt <= CW'(LOAD_CYC - 1);
          else if (cnt == '0) begin
            state <= ST_PROG;
            cnt   <= CW'(PROG_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_PROG: begin
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pb_buffer.sv
module pb_buffer #(
  parameter int DW = 8,
  parameter int BW = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld,
  input  logic                   clr,
  input  logic [BW-1:0]          byte_idx,
  input  logic [DW-1:0]          data,
  output logic [(1<<BW)*DW-1:0]  buf_flat,
  output logic [(1<<BW)-1:0]     valid,
  output logic [DW-1:0]          last_data
);
  localparam int NB = 1 << BW;

  logic [DW-1:0] slot [NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= '0;
      last_data <= '0;
      for (int i = 0; i < NB; i++) slot[i] <= '0;
    end else if (clr) begin
      valid <= '0;
    end else if (ld) begin
      slot[byte_idx]  <= data;
      valid[byte_idx] <= 1'b1;
      last_data       <= data;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_flat
    assign buf_flat[g*DW +: DW] = slot[g];
  end
endmodule

// File: rtl/pb_array.sv
module pb_array #(
  parameter int DW  = 8,
  parameter int BW  = 7,
  parameter int PIW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog,
  input  logic [PIW-1:0]        page_idx,
  input  logic [(1<<BW)*DW-1:0] buf_flat,
  input  logic [(1<<BW)-1:0]    valid,
  input  logic [PIW+BW-1:0]     rd_idx,
  output logic [DW-1:0]         rd_byte
);
  localparam int NB    = 1 << BW;
  localparam int DEPTH = 1 << (PIW + BW);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (prog) begin
      for (int b = 0; b < NB; b++)
        if (valid[b]) mem[{page_idx, BW'(b)}] <= buf_flat[b*DW +: DW];
    end
  end

  assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/pagebuf_ctrl.sv
module pagebuf_ctrl
  import pagebuf_pkg::*;
#(
  parameter int AW         = 17,
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 128,
  parameter int MEM_PAGES  = 16,
  parameter int LOAD_CYC   = 15000,
  parameter int PROG_CYC   = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          busy,
  output logic          err_page
);
  localparam int BW  = $clog2(PAGE_BYTES);
  localparam int NB  = 1 << BW;
  localparam int PW  = AW - BW;
  localparam int PIW = $clog2(MEM_PAGES);

  logic            wr_stb, rd_req, ld, prog_done;
  logic [AW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data, last_data, rd_byte;
  logic [PW-1:0]   page_tag;
  logic [NB*DW-1:0] buf_flat;
  logic [NB-1:0]   valid;
  pb_state_e       state;

  pb_strobe #(.AW(AW), .DW(DW)) u_stb (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req)
  );

  pb_ctrl #(.PW(PW), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_page(wr_addr[AW-1:BW]),
    .state(state), .page_tag(page_tag), .ld(ld), .prog_done(prog_done),
    .err_page(err_page)
  );

  pb_buffer #(.DW(DW), .BW(BW)) u_buf (
    .clk(clk), .rst_n(rst_n), .ld(ld), .clr(prog_done),
    .byte_idx(wr_addr[BW-1:0]), .data(wr_data), .buf_flat(buf_flat),
    .valid(valid), .last_data(last_data)
  );

  pb_array #(.DW(DW), .BW(BW), .PIW(PIW)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog(prog_done), .page_idx(page_tag[PIW-1:0]),
    .buf_flat(buf_flat), .valid(valid),
    .rd_idx({addr[BW +: PIW], addr[BW-1:0]}), .rd_byte(rd_byte)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '0;
    else if (rd_req)
      dout <= busy ? {~last_data[DW-1], last_data[DW-2:0]} : rd_byte;
    else dout <= '0;
  end
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int NB = 128,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          err_page,
  input logic [DW-1:0] dout,
  input logic          rd_req,
  input logic          ld,
  input logic          prog_done,
  input logic [NB-1:0] valid
);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_page |=> err_page);

  assert_busy_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ld));

  assert_busy_has_bytes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (|valid));

  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (valid == '0) && !busy);

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !prog_done) |=> $stable(valid));

  assert_dout_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (dout == '0));
endmodule

bind pagebuf_ctrl pb_checker #(.NB(NB), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err_page(err_page), .dout(dout),
  .rd_req(rd_req), .ld(ld), .prog_done(prog_done), .valid(valid)
);

// File: tb/tb_pagebuf_ctrl.sv
module tb_pagebuf_ctrl;
  localparam int L = 20;
  localparam int P = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        busy, err_page;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pagebuf_ctrl #(.LOAD_CYC(L), .PROG_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .err_page(err_page)
  );

  // page 3 load: {addr, data}; byte 5 is written twice
  localparam logic [24:0] LOADS [6] = '{
    {17'h00185, 8'h3C}, {17'h00180, 8'hA1}, {17'h001FF, 8'h7E},
    {17'h00185, 8'hC4}, {17'h001C0, 8'h55}, {17'h00181, 8'h0F}
  };
  localparam logic [24:0] EXPECT [7] = '{
    {17'h00180, 8'hA1}, {17'h00181, 8'h0F}, {17'h00185, 8'hC4},
    {17'h001C0, 8'h55}, {17'h001FF, 8'h7E}, {17'h00182, 8'hFF},
    {17'h001BF, 8'hFF}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd_byte(input logic [16:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); d = dout; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {7'd0, busy}, 8'h00);
    check("R1 err", {7'd0, err_page}, 8'h00);
    check("R1 dout", dout, 8'h00);
    rd_byte(17'h00000, v); check("R1 erased", v, 8'hFF);
    @(negedge clk); check("R10 dout idle", dout, 8'h00);

    // R4 R7 table walk: any order, overwrite, only loaded bytes
    foreach (LOADS[i]) wr_byte(LOADS[i][24:8], LOADS[i][7:0]);
    check("R5 busy after load", {7'd0, busy}, 8'h01);
    rd_byte(17'h00180, v); check("R10 poll", v, 8'h8F);
    wait_idle();
    foreach (EXPECT[i]) begin
      rd_byte(EXPECT[i][24:8], v);
      check("R4 R7 readback", v, EXPECT[i][7:0]);
    end

    // R6 R5 window restart and busy length
    wr_byte(17'h00480, 8'h21);
    repeat (L-6) @(negedge clk);
    wr_byte(17'h00481, 8'h43);
    n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    check("R5 busy length", 8'(n), 8'(L+P));
    rd_byte(17'h00480, v); check("R6 first", v, 8'h21);
    rd_byte(17'h00481, v); check("R6 restarted", v, 8'h43);

    // R9 byte after window closes is dropped
    wr_byte(17'h00500, 8'h5A);
    repeat (L-2) @(negedge clk);
    wr_byte(17'h00501, 8'hA5);
    wait_idle();
    @(negedge clk);
    check("R9 idle after", {7'd0, busy}, 8'h00);
    rd_byte(17'h00500, v); check("R9 kept", v, 8'h5A);
    rd_byte(17'h00501, v); check("R9 dropped", v, 8'hFF);

    // R2 R3 CE-controlled write, address at later fall, data at first rise
    @(negedge clk); we_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; addr = 17'h00200; din = 8'h11;
    @(negedge clk); addr = 17'h00203; ce_n = 1'b0;
    @(negedge clk); addr = 17'h00207;
    @(negedge clk); ce_n = 1'b1; din = 8'h66;
    @(negedge clk); din = 8'h77; we_n = 1'b1;
    @(negedge clk);
    wait_idle();
    rd_byte(17'h00203, v); check("R2 R3 latched", v, 8'h66);
    rd_byte(17'h00207, v); check("R2 late addr", v, 8'hFF);
    rd_byte(17'h00200, v); check("R2 early addr", v, 8'hFF);

    // R3 output enable low blocks a write
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; din = 8'h99;
    repeat (3) @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); check("R3 oe low", {7'd0, busy}, 8'h00);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    repeat (2) @(negedge clk); oe_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk); check("R3 oe abort", {7'd0, busy}, 8'h00);

    // R8 off-page byte
    wr_byte(17'h00280, 8'h12);
    wr_byte(17'h00300, 8'h34);
    check("R8 err set", {7'd0, err_page}, 8'h01);
    wait_idle();
    check("R8 err sticky", {7'd0, err_page}, 8'h01);
    rd_byte(17'h00280, v); check("R8 page kept", v, 8'h12);
    rd_byte(17'h00300, v); check("R8 off page", v, 8'hFF);

    // R1 reset again clears flag and array
    do_reset();
    @(negedge clk);
    check("R1 err cleared", {7'd0, err_page}, 8'h00);
    rd_byte(17'h00180, v); check("R1 array reset", v, 8'hFF);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule